// File: doc/BRIEF.md
# Dual-Slot SD Host Register Wrapper

This block is the register front end placed before one or two SD host slot controllers. It decodes a 4 KiB window on a plain 32-bit register bus. The first 256 bytes form a global area. That area holds a presence/control word, a debounce setting, bus, write-protect polarity and card-detect words, and a merged interrupt status word. Any other word in the area is general-purpose storage. Each slot controller owns its own 256-byte sub-window. Accesses that land in a sub-window are forwarded on a stub register port for that slot.

Each slot has two values that live in the wrapper: a capability word and a maximum-current word. Both are driven to the slot on output ports. Four alias addresses in the global area read and write these values directly. The capability word starts from a build-time constant. The wrapper samples each slot's interrupt level into the status word and ORs the implemented bits onto a single interrupt output. The bus accepts only aligned, full-word accesses. Any other access, and any access outside the decoded ranges, is rejected with a one-cycle error pulse.

Top module: `sdSlotWrap`

## Requirements
- R1: After reset, the word at 0x000 reads 0x00010000 with one slot and 0x00030000 with two slots (bit 16 = slot 0 present, bit 17 = slot 1 present). The word at 0x004 reads 0x00000005. The words at 0x008, 0x0EC, 0x0F0 and 0x0FC read zero.
- R2: A write to 0x000 stores bits 31..1 of the written data and forces bit 0 to 0, so bit 0 never reads back as 1.
- R3: The words at 0x008, 0x0EC and 0x0F0, and every global word below 0x100 with no other role, read back the last full 32-bit value written to them.
- R4: The words at 0x010 and 0x018 are slot 0's capability and maximum-current values; 0x020 and 0x028 are the same for slot 1. A write changes the value driven on `slotCap`/`slotMaxCurr` (slot n in bits 32n+31..32n). A read returns that value. Neither output changes without such a write.
- R5: After reset, every implemented slot's capability value equals the parameter `CAP_RESET`, and its maximum-current value is zero.
- R6: Bit n of the word at 0xFC equals `slotIrq[n]` as sampled at the previous rising clock edge. Writes to 0xFC have no effect.
- R7: `irqOut` is high exactly when some bit of the interrupt status word is set. It changes in the same cycle as that word.
- R8: A valid access at 0x100*(n+1)+k raises only `slotSel[n]` in the same cycle. In that cycle `slotAddr`=k, and `slotWrite` and `slotWdata` carry the bus values. The read result is the slot's `slotRdata` word. With no bus access, `slotSel` is zero.
- R9: An access is rejected if its byte enables are not 4'b1111, its address bits 1..0 are nonzero, or its address bits 11..8 exceed the slot count. A rejected access writes nothing, reads as zero, and raises `busErr` for exactly the one cycle after the request.
- R10: With one slot, the slot 1 sub-window is rejected as in R9. The aliases 0x020/0x028 read zero, ignore writes and raise no error.
- R11: Read data and `busRvalid` appear in the cycle after a read request. `busRvalid` is low in any cycle that does not follow a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access request, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte address in the window |
| busByteEn | input | 4 | Byte enables; only 4'b1111 is accepted |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, registered |
| busRvalid | output | 1 | Read data valid |
| busErr | output | 1 | Rejected-access pulse |
| slotSel | output | SLOTS | Per-slot sub-window select |
| slotWrite | output | 1 | Write flag forwarded to slots |
| slotAddr | output | 8 | Byte offset inside the sub-window |
| slotWdata | output | 32 | Write data forwarded to slots |
| slotRdata | input | 32*SLOTS | Per-slot read data |
| slotCap | output | 32*SLOTS | Per-slot capability value |
| slotMaxCurr | output | 32*SLOTS | Per-slot maximum-current value |
| slotIrq | input | SLOTS | Per-slot interrupt levels |
| irqOut | output | 1 | Merged interrupt |

## Verification
Every read result, `busRvalid` and `busErr` are registered, so each is due one edge after the request cycle. Slot forwarding (`slotSel`, `slotAddr`, `slotWrite`, `slotWdata`) is combinational and is due in the request cycle itself. The interrupt status word and `irqOut` lag `slotIrq` by exactly one edge. The bench drives every input at a falling edge. It checks forwarding a moment after driving, checks registered results at the next falling edge, and samples `irqOut` both before and after the edge to confirm the single-cycle lag.

// File: rtl/sdWrapPkg.sv
package sdWrapPkg;
  localparam int DW        = 32;
  localparam int WIN_AW    = 12;
  localparam int SUB_AW    = 8;
  localparam int REGION_W  = WIN_AW - SUB_AW;
  localparam int WORD_W    = SUB_AW - 2;
  localparam int GLB_WORDS = 1 << WORD_W;
  localparam int MAX_SLOTS = 2;

  // word indices inside the global area
  localparam logic [WORD_W-1:0] W_INFO = 6'd0;
  localparam logic [WORD_W-1:0] W_DEB  = 6'd1;
  localparam logic [WORD_W-1:0] W_CAP0 = 6'd4;
  localparam logic [WORD_W-1:0] W_MC0  = 6'd6;
  localparam logic [WORD_W-1:0] W_CAP1 = 6'd8;
  localparam logic [WORD_W-1:0] W_MC1  = 6'd10;
  localparam logic [WORD_W-1:0] W_IRQ  = 6'd63;

  localparam int PRES0_BIT = 16;
  localparam int PRES1_BIT = 17;

  typedef struct packed {
    logic                  glbHit;
    logic [MAX_SLOTS-1:0]  slotHit;
    logic [WORD_W-1:0]     word;
    logic                  isWrite;
    logic                  rdReq;
    logic                  aliasHit;
    logic                  aliasValid;
    logic                  aliasSlot;
    logic                  aliasIsMc;
    logic                  irqSel;
    logic                  infoSel;
  } strobe_t;
endpackage

// File: rtl/sdWrapCtrl.sv
module sdWrapCtrl
  import sdWrapPkg::*;
#(
  parameter int SLOTS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [WIN_AW-1:0] busAddr,
  input  logic [3:0]        busByteEn,
  output strobe_t           stb,
  output logic              rvalidQ,
  output logic              errQ
);
  logic [REGION_W-1:0]  region;
  logic [WORD_W-1:0]    word;
  logic                 accessOk;
  logic                 glbHit;
  logic [MAX_SLOTS-1:0] hitVec;
  logic                 aliasHit;
  logic                 aliasSlot;

  assign region   = busAddr[WIN_AW-1:SUB_AW];
  assign word     = busAddr[SUB_AW-1:2];
  assign accessOk = busSel && (busByteEn == 4'hF) && (busAddr[1:0] == 2'b00);
  assign glbHit   = accessOk && (region == '0);

  generate
    for (genvar i = 0; i < MAX_SLOTS; i++) begin : g_hit
      if (i < SLOTS) begin : g_on
        assign hitVec[i] = accessOk && (region == REGION_W'(i + 1));
      end else begin : g_off
        assign hitVec[i] = 1'b0;
      end
    end
  endgenerate

  assign aliasHit  = glbHit && (word == W_CAP0 || word == W_MC0 ||
                                word == W_CAP1 || word == W_MC1);
  assign aliasSlot = (word == W_CAP1) || (word == W_MC1);

  always_comb begin
    stb            = '0;
    stb.glbHit     = glbHit;
    stb.slotHit    = hitVec;
    stb.word       = word;
    stb.isWrite    = busWrite;
    stb.rdReq      = busSel && !busWrite;
    stb.aliasHit   = aliasHit;
    stb.aliasSlot  = aliasSlot;
    stb.aliasIsMc  = (word == W_MC0) || (word == W_MC1);
    stb.aliasValid = aliasHit && (SLOTS > 1 || !aliasSlot);
    stb.irqSel     = glbHit && (word == W_IRQ);
    stb.infoSel    = glbHit && (word == W_INFO);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rvalidQ <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      rvalidQ <= busSel && !busWrite;
      errQ    <= busSel && !(glbHit || (|hitVec));
    end
  end
endmodule

// File: rtl/sdWrapData.sv
module sdWrapData
  import sdWrapPkg::*;
#(
  parameter int          SLOTS          = 2,
  parameter logic [31:0] CAP_RESET      = 32'h01E8_0080,
  parameter logic [31:0] DEBOUNCE_RESET = 32'h0000_0005
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 stb,
  input  logic [DW-1:0]           wdata,
  input  logic [SLOTS-1:0]        slotIrq,
  input  logic [SLOTS*DW-1:0]     slotRdata,
  output logic [DW-1:0]           rdataQ,
  output logic [MAX_SLOTS*DW-1:0] capFlat,
  output logic [MAX_SLOTS*DW-1:0] mcFlat,
  output logic                    irqOut
);
  localparam logic [DW-1:0] INFO_RST =
    (DW'(1) << PRES0_BIT) | ((SLOTS > 1) ? (DW'(1) << PRES1_BIT) : '0);

  logic [DW-1:0]                  glbMem [GLB_WORDS];
  logic [MAX_SLOTS-1:0][DW-1:0]   capQ;
  logic [MAX_SLOTS-1:0][DW-1:0]   mcQ;
  logic [MAX_SLOTS-1:0]           irqStat;
  logic [MAX_SLOTS-1:0]           irqPad;
  logic [MAX_SLOTS*DW-1:0]        rdPad;
  logic [DW-1:0]                  rdNext;
  logic                           glbStoreWr;

  assign irqPad     = MAX_SLOTS'(slotIrq);
  assign rdPad      = (MAX_SLOTS*DW)'(slotRdata);
  assign glbStoreWr = stb.glbHit && stb.isWrite && !stb.aliasHit && !stb.irqSel;

  // global storage, info word bit 0 self-clears on write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < GLB_WORDS; k++) begin
        if (k == int'(W_INFO))     glbMem[k] <= INFO_RST;
        else if (k == int'(W_DEB)) glbMem[k] <= DEBOUNCE_RESET;
        else                       glbMem[k] <= '0;
      end
    end else if (glbStoreWr) begin
      glbMem[stb.word] <= stb.infoSel ? (wdata & ~DW'(1)) : wdata;
    end
  end

  // per-slot capability / max-current values reached through aliases
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MAX_SLOTS; i++) begin
        capQ[i] <= (i < SLOTS) ? CAP_RESET : '0;
        mcQ[i]  <= '0;
      end
    end else if (stb.aliasValid && stb.isWrite) begin
      for (int i = 0; i < MAX_SLOTS; i++) begin
        if (int'(stb.aliasSlot) == i) begin
          if (stb.aliasIsMc) mcQ[i]  <= wdata;
          else               capQ[i] <= wdata;
        end
      end
    end
  end

  // interrupt status follows slot levels
  always_ff @(posedge clk) begin
    if (!rstN) irqStat <= '0;
    else       irqStat <= irqPad;
  end

  assign irqOut = |irqStat;

  always_comb begin
    rdNext = '0;
    if (stb.glbHit) begin
      if (stb.irqSel)
        rdNext = DW'(irqStat);
      else if (stb.aliasHit)
        rdNext = !stb.aliasValid ? '0 :
                 stb.aliasIsMc ? mcQ[stb.aliasSlot] : capQ[stb.aliasSlot];
      else
        rdNext = glbMem[stb.word];
    end
    for (int i = 0; i < MAX_SLOTS; i++) begin
      if (stb.slotHit[i]) rdNext = rdPad[i*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdataQ <= '0;
    else if (stb.rdReq) rdataQ <= rdNext;
  end

  generate
    for (genvar i = 0; i < MAX_SLOTS; i++) begin : g_flat
      assign capFlat[i*DW +: DW] = capQ[i];
      assign mcFlat[i*DW +: DW]  = mcQ[i];
    end
  endgenerate
endmodule

// File: rtl/sdSlotWrap.sv
module sdSlotWrap
  import sdWrapPkg::*;
#(
  parameter int          SLOTS          = 2,
  parameter logic [31:0] CAP_RESET      = 32'h01E8_0080,
  parameter logic [31:0] DEBOUNCE_RESET = 32'h0000_0005
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busWrite,
  input  logic [11:0]         busAddr,
  input  logic [3:0]          busByteEn,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  output logic                busRvalid,
  output logic                busErr,
  output logic [SLOTS-1:0]    slotSel,
  output logic                slotWrite,
  output logic [7:0]          slotAddr,
  output logic [31:0]         slotWdata,
  input  logic [SLOTS*32-1:0] slotRdata,
  output logic [SLOTS*32-1:0] slotCap,
  output logic [SLOTS*32-1:0] slotMaxCurr,
  input  logic [SLOTS-1:0]    slotIrq,
  output logic                irqOut
);
  strobe_t                 stb;
  logic [MAX_SLOTS*DW-1:0] capFlat;
  logic [MAX_SLOTS*DW-1:0] mcFlat;

  sdWrapCtrl #(.SLOTS(SLOTS)) ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busByteEn(busByteEn), .stb(stb),
    .rvalidQ(busRvalid), .errQ(busErr)
  );

  sdWrapData #(
    .SLOTS(SLOTS), .CAP_RESET(CAP_RESET), .DEBOUNCE_RESET(DEBOUNCE_RESET)
  ) data (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(busWdata),
    .slotIrq(slotIrq), .slotRdata(slotRdata), .rdataQ(busRdata),
    .capFlat(capFlat), .mcFlat(mcFlat), .irqOut(irqOut)
  );

  assign slotSel     = stb.slotHit[SLOTS-1:0];
  assign slotWrite   = busWrite;
  assign slotAddr    = busAddr[SUB_AW-1:0];
  assign slotWdata   = busWdata;
  assign slotCap     = capFlat[SLOTS*DW-1:0];
  assign slotMaxCurr = mcFlat[SLOTS*DW-1:0];
endmodule

// File: rtl/sdSlotWrapChk.sv
module sdSlotWrapChk #(
  parameter int SLOTS = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic                busSel,
  input logic                busWrite,
  input logic [11:0]         busAddr,
  input logic [3:0]          busByteEn,
  input logic [31:0]         busRdata,
  input logic                busRvalid,
  input logic                busErr,
  input logic [SLOTS-1:0]    slotSel,
  input logic [SLOTS-1:0]    slotIrq,
  input logic                irqOut,
  input logic [SLOTS*32-1:0] slotCap
);
  AST_INFO_BIT0_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $past(busSel && !busWrite && busAddr == 12'h000 && busByteEn == 4'hF)
      |-> busRdata[0] == 1'b0);  // R2

  AST_CAP_HELD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(busSel && busWrite)) |-> $stable(slotCap));  // R4

  AST_IRQ_MERGE: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (irqOut == (|$past(slotIrq))));  // R7

  AST_SLOT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(slotSel));  // R8

  AST_SLOT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busSel |-> slotSel == '0);  // R8

  AST_RANGE_ERR: assert property (@(posedge clk) disable iff (!rstN)
    $past(busSel && busAddr[11:8] > 4'(SLOTS)) |-> busErr);  // R9

  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busErr && busRvalid) |-> busRdata == 32'h0);  // R9

  AST_RVALID_LAG: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (busRvalid == $past(busSel && !busWrite)));  // R11
endmodule

bind sdSlotWrap sdSlotWrapChk #(.SLOTS(SLOTS)) chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
  .busAddr(busAddr), .busByteEn(busByteEn), .busRdata(busRdata),
  .busRvalid(busRvalid), .busErr(busErr), .slotSel(slotSel),
  .slotIrq(slotIrq), .irqOut(irqOut), .slotCap(slotCap)
);

// File: tb/sdSlotWrap_test.sv
module sdSlotWrap_test;
  localparam logic [31:0] CAP = 32'h01E8_0080;

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 12'h000, 32'hDEAD_BEEF, 32'h0, 4'd2},
    '{1'b0, 12'h000, 32'h0, 32'hDEAD_BEEE, 4'd2},          // R2
    '{1'b1, 12'h008, 32'h1234_5678, 32'h0, 4'd3},
    '{1'b0, 12'h008, 32'h0, 32'h1234_5678, 4'd3},          // R3
    '{1'b1, 12'h0EC, 32'h0000_00A5, 32'h0, 4'd3},
    '{1'b0, 12'h0EC, 32'h0, 32'h0000_00A5, 4'd3},          // R3
    '{1'b1, 12'h0F0, 32'hFFFF_0001, 32'h0, 4'd3},
    '{1'b0, 12'h0F0, 32'h0, 32'hFFFF_0001, 4'd3},          // R3
    '{1'b1, 12'h034, 32'hCAFE_0034, 32'h0, 4'd3},
    '{1'b0, 12'h034, 32'h0, 32'hCAFE_0034, 4'd3},          // R3 spare word
    '{1'b1, 12'h018, 32'h0000_0123, 32'h0, 4'd4},
    '{1'b0, 12'h018, 32'h0, 32'h0000_0123, 4'd4},          // R4
    '{1'b1, 12'h028, 32'h0000_0456, 32'h0, 4'd4},
    '{1'b0, 12'h028, 32'h0, 32'h0000_0456, 4'd4},          // R4
    '{1'b1, 12'h0FC, 32'hFFFF_FFFF, 32'h0, 4'd6},
    '{1'b0, 12'h0FC, 32'h0, 32'h0000_0000, 4'd6}           // R6 write ignored
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic        busSel = 1'b0, busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [3:0]  busByteEn = 4'hF;
  logic [31:0] busWdata = '0;
  logic [1:0]  irq2 = '0;
  logic        irq1 = 1'b0;

  logic [31:0] rd2, rd1;
  logic        rv2, rv1, er2, er1, io2, io1, sw2, sw1;
  logic [1:0]  sel2;
  logic        sel1;
  logic [7:0]  sAddr2, sAddr1;
  logic [31:0] sWd2, sWd1;
  logic [63:0] sRd2, cap2, mc2;
  logic [31:0] sRd1, cap1, mc1;

  // stub slot read data: 5A, slot index, 00, offset
  always_comb begin
    sRd2 = {8'h5A, 8'h01, 8'h00, sAddr2, 8'h5A, 8'h00, 8'h00, sAddr2};
    sRd1 = {8'h5A, 8'h00, 8'h00, sAddr1};
  end

  sdSlotWrap #(.SLOTS(2), .CAP_RESET(CAP)) uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busByteEn(busByteEn), .busWdata(busWdata),
    .busRdata(rd2), .busRvalid(rv2), .busErr(er2), .slotSel(sel2),
    .slotWrite(sw2), .slotAddr(sAddr2), .slotWdata(sWd2), .slotRdata(sRd2),
    .slotCap(cap2), .slotMaxCurr(mc2), .slotIrq(irq2), .irqOut(io2)
  );

  sdSlotWrap #(.SLOTS(1), .CAP_RESET(CAP)) uut1 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busByteEn(busByteEn), .busWdata(busWdata),
    .busRdata(rd1), .busRvalid(rv1), .busErr(er1), .slotSel(sel1),
    .slotWrite(sw1), .slotAddr(sAddr1), .slotWdata(sWd1), .slotRdata(sRd1),
    .slotCap(cap1), .slotMaxCurr(mc1), .slotIrq(irq1), .irqOut(io1)
  );

  int errors = 0;
  int checks = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one access; returns at the falling edge after the capturing rising edge
  task automatic acc(input logic wr, input logic [11:0] a, input logic [31:0] d,
                     input logic [3:0] be);
    @(negedge clk);
    busSel = 1'b1; busWrite = wr; busAddr = a; busWdata = d; busByteEn = be;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; busByteEn = 4'hF;
  endtask

  task automatic rd(input logic [11:0] a);
    acc(1'b0, a, 32'h0, 4'hF);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values
    rd(12'h000); chk("R1 info 2slot", rd2, 32'h0003_0000); chk("R1 info 1slot", rd1, 32'h0001_0000);
    rd(12'h004); chk("R1 debounce", rd2, 32'h0000_0005);
    rd(12'h0EC); chk("R1 wp polarity", rd2, 32'h0);
    rd(12'h0FC); chk("R1 irq status", rd2, 32'h0);
    // R5 capability reset
    chk("R5 cap port slot0", cap2[31:0], CAP);
    chk("R5 cap port slot1", cap2[63:32], CAP);
    chk("R5 maxcurr port", mc2[31:0], 32'h0);
    rd(12'h020); chk("R5 cap alias slot1", rd2, CAP);

    // table walk
    for (int v = 0; v < NV; v++) begin
      acc(VECS[v].wr, VECS[v].addr, VECS[v].data, 4'hF);
      if (!VECS[v].wr) begin
        checks++;
        if (rd2 !== VECS[v].exp) begin
          errors++;
          $display("FAIL R%0d vector %0d: actual=%h expected=%h", VECS[v].req, v, rd2, VECS[v].exp);
        end
      end
    end

    // R4 alias writes reach the ports
    chk("R4 maxcurr port slot0", mc2[31:0], 32'h0000_0123);
    chk("R4 maxcurr port slot1", mc2[63:32], 32'h0000_0456);
    acc(1'b1, 12'h010, 32'hAAAA_0001, 4'hF);
    chk("R4 cap port slot0", cap2[31:0], 32'hAAAA_0001);
    chk("R4 cap slot1 untouched", cap2[63:32], CAP);
    rd(12'h010); chk("R4 cap alias read", rd2, 32'hAAAA_0001);

    // R10 single slot: slot-1 aliases inert, no error
    rd(12'h028); chk("R10 alias read zero", rd1, 32'h0); chk("R10 alias no err", {31'b0, er1}, 32'h0);
    chk("R10 maxcurr slot0 only", mc1, 32'h0000_0123);

    // R11 read valid timing
    rd(12'h008); chk("R11 rvalid after read", {31'b0, rv2}, 32'h1);
    @(posedge clk); @(negedge clk);
    chk("R11 rvalid idle", {31'b0, rv2}, 32'h0);

    // R8 slot forwarding, checked in the request cycle
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = 12'h1A4; busWdata = 32'h0000_0077;
    #1;
    chk("R8 slotSel", {30'b0, sel2}, 32'h1);
    chk("R8 slotAddr", {24'b0, sAddr2}, 32'h0000_00A4);
    chk("R8 slotWrite", {31'b0, sw2}, 32'h1);
    chk("R8 slotWdata", sWd2, 32'h0000_0077);
    @(posedge clk); @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
    rd(12'h244); chk("R8 slot1 read data", rd2, 32'h5A01_0044);
    chk("R10 slot1 window rejected", {31'b0, er1}, 32'h1);
    chk("R10 rejected read zero", rd1, 32'h0);

    // R9 rejects
    rd(12'h300); chk("R9 out of range err", {31'b0, er2}, 32'h1); chk("R9 out of range data", rd2, 32'h0);
    @(posedge clk); @(negedge clk);
    chk("R9 err is one pulse", {31'b0, er2}, 32'h0);
    acc(1'b1, 12'h008, 32'h0, 4'h3); chk("R9 partial write err", {31'b0, er2}, 32'h1);
    rd(12'h008); chk("R9 partial write ignored", rd2, 32'h1234_5678);
    rd(12'h00A); chk("R9 misaligned err", {31'b0, er2}, 32'h1); chk("R9 misaligned data", rd2, 32'h0);

    // R6/R7 interrupt merge with one-cycle lag
    @(negedge clk);
    irq2 = 2'b10; irq1 = 1'b0;
    #1; chk("R6 irq not yet sampled", {31'b0, io2}, 32'h0);
    @(posedge clk); @(negedge clk);
    chk("R7 irqOut raised", {31'b0, io2}, 32'h1);
    chk("R7 single slot quiet", {31'b0, io1}, 32'h0);
    rd(12'h0FC); chk("R6 status bit1", rd2, 32'h0000_0002);
    @(negedge clk);
    irq2 = 2'b00; irq1 = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R7 irqOut lowered", {31'b0, io2}, 32'h0);
    chk("R7 single slot raised", {31'b0, io1}, 32'h1);
    rd(12'h0FC); chk("R6 status cleared", rd2, 32'h0); chk("R6 single slot bit0", rd1, 32'h1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule